// File: doc/BRIEF.md
# Folded Symmetric Image FIR with Pre-Adders and Interleave Delays

This block filters a stream of signed image samples with a sixteen-tap horizontal FIR that is folded around its centre. The samples travel through two chains of delay stages. A forward chain gives the newer half of the taps, and a reverse chain, fed from the end of the forward chain, gives the older half. For each of eight coefficient positions, a pre-adder combines one sample from each chain, so one multiplier serves two taps. An adder tree then sums the eight products at full precision.

Run-time fields choose how the mirrored samples are combined. The choices are a sum for even-symmetric coefficient sets, a difference for odd-symmetric sets, or one operand forced to zero for asymmetric sets. A further field chooses an even-tap or an odd-tap fold. In the odd-tap fold the centre sample passes through alone. Every delay stage has a programmable length from 1 to 16 samples. Up to sixteen interleaved data sets, multiplexed sample by sample, are therefore each filtered on their own, without being separated first. The delay stages advance only on valid samples. The result appears a fixed number of cycles after its sample, whatever the length setting.

Top module: `fold_fir`

## Requirements
- R1: While reset is low, and on the first cycle after it, `outValid` is 0 and `outResult` is 0.
- R2: A sample accepted with `inValid` high at a clock edge produces `outValid` high for exactly one cycle, three edges later. `outValid` is never high otherwise, and `outResult` holds its value while `outValid` is low.
- R3: Let x(m) be the sample accepted m·L valid samples before the current one, with x(0) the current sample. With `shapeCfg[0]`=0 (even-tap fold), position k (0..7) pairs A=x(k) with B=x(15−k). The result is the sum over k of coefficient k times the pre-adder output. Coefficient k sits in `coefFlat[12k+11:12k]`.
- R4: `aluCfg[0]`=0 makes every pre-adder output A+B. `aluCfg[0]`=1 makes it B−A.
- R5: `aluCfg[1]`=1 forces A to zero, and `aluCfg[2]`=1 forces B to zero. With both set, the result is 0.
- R6: With `shapeCfg[0]`=1 (odd-tap fold), positions 0..6 pair x(k) with x(14−k). Position 7 passes x(7) alone: its B is zero, `aluCfg[0]` is ignored there, and `aluCfg[1]` still zeroes it.
- R7: `shapeCfg[4:1]` holds the stage length L minus one (0 gives L=1, 15 gives L=16). Taps are spaced L valid samples apart, so L interleaved sets are filtered independently.
- R8: Cycles with `inValid` low do not advance the delay stages. They do not change the taps used for the next valid sample.
- R9: Coefficients, `aluCfg` and `shapeCfg` are taken on the cycle of each valid sample. A change applies from the next valid sample onward.
- R10: Changing L does not clear the delay stages. The first stage's previous contents are used straight after the change.
- R11: The result is the exact full-precision sum, sign-extended into 30 bits, even for the extreme values −2048 and 2047 on every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample strobe |
| inSample | input | 12 | Signed input sample |
| coefFlat | input | 96 | Eight signed 12-bit coefficients, coefficient k at bits 12k+11:12k |
| aluCfg | input | 3 | Bit 0 selects difference, bit 1 zeroes operand A, bit 2 zeroes operand B |
| shapeCfg | input | 5 | Bit 0 selects the odd-tap fold, bits 4:1 hold the stage length minus one |
| outValid | output | 1 | Result strobe |
| outResult | output | 30 | Signed filter result |

## Verification
The hardest state to reach from the ports is a long stage length, such as sixteen, where every one of the fifteen stages has been refilled after a change of length or fold. A tap then depends on a sample up to 240 valid samples back. The stimulus changes the shape and then streams several hundred valid samples, with random gaps, before the reference model compares results again. A separate directed phase shortens the length and uses only the first stage's output at once. In that phase a cleared stage shows up as a zero product. Per-sample changes of coefficients and ALU fields show that each setting applies to exactly its own sample.

// File: rtl/fold_fir_pkg.sv
package fold_fir_pkg;
  typedef struct packed {
    logic shift;
    logic capPre;
    logic capProd;
    logic capSum;
  } fir_strobe_t;
endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fold_fir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output fir_strobe_t strb,
  output logic        outValid
);
  logic vPre, vProd, vSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPre  <= 1'b0;
      vProd <= 1'b0;
      vSum  <= 1'b0;
    end else begin
      vPre  <= inValid;
      vProd <= vPre;
      vSum  <= vProd;
    end
  end

  always_comb begin
    strb.shift   = inValid;
    strb.capPre  = inValid;
    strb.capProd = vPre;
    strb.capSum  = vProd;
  end

  assign outValid = vSum;
endmodule

// File: rtl/fir_delay_stage.sv
module fir_delay_stage #(
  parameter int W     = 12,
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          shift,
  input  logic [LW-1:0] lenSel,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else if (shift) begin
      sr[0] <= din;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  assign dout = sr[lenSel];
endmodule

// File: rtl/fir_datapath.sv
module fir_datapath
  import fold_fir_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 12,
  parameter int PAIRS    = 8,
  parameter int MAX_LEN  = 16,
  parameter int RES_W    = 30,
  parameter int LEN_W    = $clog2(MAX_LEN)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fir_strobe_t               strb,
  input  logic [SAMPLE_W-1:0]       sample,
  input  logic [PAIRS*COEF_W-1:0]   coefFlat,
  input  logic [2:0]                aluCfg,
  input  logic [LEN_W:0]            shapeCfg,
  output logic [RES_W-1:0]          result
);
  localparam int PRE_W  = SAMPLE_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;

  logic [LEN_W-1:0]    lenSel;
  logic                oddMode;
  logic [SAMPLE_W-1:0] fwdTap [PAIRS];
  logic [SAMPLE_W-1:0] revTap [PAIRS];
  logic [SAMPLE_W-1:0] headOut;

  logic signed [PRE_W-1:0]  preSum  [PAIRS];
  logic signed [PRE_W-1:0]  preReg  [PAIRS];
  logic signed [COEF_W-1:0] coefReg [PAIRS];
  logic signed [PROD_W-1:0] prodReg [PAIRS];
  logic signed [RES_W-1:0]  sumAll;

  assign lenSel    = shapeCfg[LEN_W:1];
  assign oddMode   = shapeCfg[0];
  assign fwdTap[0] = sample;

  // forward chain: newer half of the taps
  for (genvar k = 1; k < PAIRS; k++) begin : g_fwd
    fir_delay_stage #(.W(SAMPLE_W), .DEPTH(MAX_LEN), .LW(LEN_W)) u_stage (
      .clk(clk), .rstN(rstN), .shift(strb.shift), .lenSel(lenSel),
      .din(fwdTap[k-1]), .dout(fwdTap[k]));
  end

  // head of reverse chain, bypassed in the odd-tap fold
  fir_delay_stage #(.W(SAMPLE_W), .DEPTH(MAX_LEN), .LW(LEN_W)) u_head (
    .clk(clk), .rstN(rstN), .shift(strb.shift), .lenSel(lenSel),
    .din(fwdTap[PAIRS-1]), .dout(headOut));

  assign revTap[0] = oddMode ? fwdTap[PAIRS-1] : headOut;

  for (genvar j = 1; j < PAIRS; j++) begin : g_rev
    fir_delay_stage #(.W(SAMPLE_W), .DEPTH(MAX_LEN), .LW(LEN_W)) u_stage (
      .clk(clk), .rstN(rstN), .shift(strb.shift), .lenSel(lenSel),
      .din(revTap[j-1]), .dout(revTap[j]));
  end

  // pre-adders
  for (genvar k = 0; k < PAIRS; k++) begin : g_pre
    logic signed [PRE_W-1:0] opA, opB;
    logic isCentre;
    assign isCentre = oddMode && (k == PAIRS - 1);
    assign opA = aluCfg[1] ? '0 : PRE_W'($signed(fwdTap[k]));
    assign opB = (aluCfg[2] || isCentre) ? '0 : PRE_W'($signed(revTap[PAIRS-1-k]));
    assign preSum[k] = (aluCfg[0] && !isCentre) ? (opB - opA) : (opA + opB);
  end

  always_comb begin
    sumAll = '0;
    for (int k = 0; k < PAIRS; k++) sumAll = sumAll + RES_W'(prodReg[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < PAIRS; k++) begin
        preReg[k]  <= '0;
        coefReg[k] <= '0;
        prodReg[k] <= '0;
      end
      result <= '0;
    end else begin
      if (strb.capPre) begin
        for (int k = 0; k < PAIRS; k++) begin
          preReg[k]  <= preSum[k];
          coefReg[k] <= $signed(coefFlat[k*COEF_W +: COEF_W]);
        end
      end
      if (strb.capProd) begin
        for (int k = 0; k < PAIRS; k++)
          prodReg[k] <= PROD_W'(preReg[k]) * PROD_W'(coefReg[k]);
      end
      if (strb.capSum) result <= sumAll;
    end
  end
endmodule

// File: rtl/fold_fir.sv
module fold_fir
  import fold_fir_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 12,
  parameter int PAIRS    = 8,
  parameter int MAX_LEN  = 16,
  parameter int RES_W    = 30,
  parameter int LEN_W    = $clog2(MAX_LEN)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [SAMPLE_W-1:0]     inSample,
  input  logic [PAIRS*COEF_W-1:0] coefFlat,
  input  logic [2:0]              aluCfg,
  input  logic [LEN_W:0]          shapeCfg,
  output logic                    outValid,
  output logic [RES_W-1:0]        outResult
);
  fir_strobe_t strb;

  fir_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strb(strb), .outValid(outValid));

  fir_datapath #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .PAIRS(PAIRS),
    .MAX_LEN(MAX_LEN), .RES_W(RES_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sample(inSample),
    .coefFlat(coefFlat), .aluCfg(aluCfg), .shapeCfg(shapeCfg), .result(outResult));
endmodule

// File: rtl/fold_fir_chk.sv
module fold_fir_chk #(
  parameter int RES_W = 30
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic [RES_W-1:0] outResult
);
  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##2 outValid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 3));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outResult));

  // R11
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outResult[RES_W-1:RES_W-3] == 3'b000 ||
                  outResult[RES_W-1:RES_W-3] == 3'b111));
endmodule

bind fold_fir fold_fir_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid),
  .outValid(outValid), .outResult(outResult));

// File: tb/test_fold_fir.sv
module test_fold_fir;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [11:0] inSample = '0;
  logic [95:0] coefFlat = '0;
  logic [2:0]  aluCfg = '0;
  logic [4:0]  shapeCfg = '0;
  logic        outValid;
  logic [29:0] outResult;

  fold_fir i_fold_fir (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .coefFlat(coefFlat), .aluCfg(aluCfg), .shapeCfg(shapeCfg),
    .outValid(outValid), .outResult(outResult));

  always #2 clk = ~clk;

  int     nCmp = 0, nBad = 0;
  bit     done = 0;
  int     nxCoef [8];
  int     nxAlu = 0, nxLen = 1;
  bit     nxOdd = 0;
  int     hist [$];
  int     settle = 100000;
  bit     forceChk = 0;
  string  tag = "R3";
  bit     pV [3];
  bit     pC [3];
  longint pR [3];
  string  pT [3];

  function automatic int xs(int m, int L);
    int idx = hist.size() - 1 - m * L;
    return (idx >= 0) ? hist[idx] : 0;
  endfunction

  function automatic longint refOut();
    longint acc = 0;
    for (int k = 0; k < 8; k++) begin
      int a, b, p;
      bit centre;
      centre = nxOdd && (k == 7);
      a = nxAlu[1] ? 0 : xs(k, nxLen);
      b = (nxAlu[2] || centre) ? 0 : xs(nxOdd ? 14 - k : 15 - k, nxLen);
      p = (nxAlu[0] && !centre) ? b - a : a + b;
      acc += longint'(p) * longint'(nxCoef[k]);
    end
    return acc;
  endfunction

  task automatic checkOut();
    longint got;
    nCmp++;
    if (outValid !== pV[2]) begin
      nBad++;
      $display("FAIL R2 outValid=%0d expected %0d", outValid, pV[2]);
    end
    if (pV[2] && pC[2]) begin
      nCmp++;
      got = $signed(outResult);
      if (got !== pR[2]) begin
        nBad++;
        $display("FAIL %s outResult=%0d expected %0d", pT[2], got, pR[2]);
      end
    end
  endtask

  task automatic step(bit v, int s);
    logic [4:0] newShape;
    @(negedge clk);
    checkOut();
    newShape = {4'(nxLen - 1), nxOdd};
    if (newShape !== shapeCfg) settle = 0;
    shapeCfg = newShape;
    aluCfg   = nxAlu[2:0];
    for (int k = 0; k < 8; k++) coefFlat[k*12 +: 12] = nxCoef[k][11:0];
    inValid  = v;
    inSample = s[11:0];
    for (int i = 2; i > 0; i--) begin
      pV[i] = pV[i-1]; pC[i] = pC[i-1]; pR[i] = pR[i-1]; pT[i] = pT[i-1];
    end
    pV[0] = v;
    pT[0] = tag;
    if (v) begin
      hist.push_back(s);
      pC[0] = forceChk || (settle >= 15 * nxLen);
      pR[0] = refOut();
      settle++;
    end else begin
      pC[0] = 0;
      pR[0] = 0;
    end
  endtask

  function automatic int rndS();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  task automatic randCoefs();
    for (int k = 0; k < 8; k++) nxCoef[k] = rndS();
  endtask

  task automatic run(int n, int pct);
    for (int i = 0; i < n; i++) step(($urandom_range(99) < pct), rndS());
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      pV[i] = 0; pC[i] = 0; pR[i] = 0; pT[i] = "R2";
    end
    for (int k = 0; k < 8; k++) nxCoef[k] = 0;
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      nCmp++;
      if (outValid !== 1'b0 || outResult !== '0) begin
        nBad++;
        $display("FAIL R1 outValid=%0d outResult=%0d expected 0 0", outValid, outResult);
      end
    end
    rstN = 1'b1;
    @(negedge clk);
    nCmp++;
    if (outValid !== 1'b0 || outResult !== '0) begin
      nBad++;
      $display("FAIL R1 after release outValid=%0d outResult=%0d expected 0 0", outValid, outResult);
    end

    // R3 sum, even fold, L=1
    tag = "R3"; randCoefs(); nxAlu = 0; run(300, 70);
    // R4 difference
    tag = "R4"; nxAlu = 1; randCoefs(); run(300, 70);
    // R5 operand zeroing
    tag = "R5"; nxAlu = 2; run(150, 80);
    nxAlu = 4; run(150, 80);
    nxAlu = 6; run(100, 80);
    nxAlu = 3; run(100, 80);
    // R6 odd fold
    tag = "R6"; nxOdd = 1; nxAlu = 0; run(300, 80);
    nxAlu = 1; run(200, 80);
    nxAlu = 2; run(150, 80);
    nxAlu = 5; run(150, 80);
    // R7 interleave lengths
    tag = "R7"; nxOdd = 0; nxLen = 2; nxAlu = 0; randCoefs(); run(400, 75);
    nxOdd = 1; nxLen = 3; nxAlu = 1; run(400, 75);
    nxOdd = 0; nxLen = 16; nxAlu = 0; run(700, 85);
    // R8 idle gaps
    tag = "R8"; run(300, 10);
    for (int i = 0; i < 60; i++) step(0, rndS());
    run(200, 50);
    // R9 per-sample configuration changes
    tag = "R9";
    for (int i = 0; i < 300; i++) begin
      nxAlu = int'($urandom_range(7));
      randCoefs();
      step(($urandom_range(99) < 70), rndS());
    end
    // R10 length change keeps stage contents
    tag = "R10"; nxLen = 2; nxAlu = 0; run(100, 90);
    for (int k = 0; k < 8; k++) nxCoef[k] = 0;
    nxCoef[1] = 1531; nxAlu = 4; nxLen = 1; forceChk = 1;
    run(40, 100);
    forceChk = 0;
    // R11 extremes
    tag = "R11"; nxAlu = 0; for (int k = 0; k < 8; k++) nxCoef[k] = -2048;
    for (int i = 0; i < 40; i++) step(1, -2048);
    for (int i = 0; i < 300; i++) begin
      nxAlu = int'($urandom_range(1));
      for (int k = 0; k < 8; k++) nxCoef[k] = $urandom_range(1) ? 2047 : -2048;
      step(1, $urandom_range(1) ? 2047 : -2048);
    end
    run(10, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      nBad++;
      nCmp++;
      $display("FAIL watchdog expired before end of stimulus");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule